// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a small data cache placed between a processor's load/store port and the external memory interface. It holds 256 bytes as sixteen lines of four 32-bit words, with one way per set. Each line keeps one tag and one valid bit per word. The tag holds the upper 24 address bits and the 3-bit address-space code of the access. Lookups are combinational. The CPU sees a hit flag and the read data in the same cycle it presents the address.

Every store is passed straight to the memory write port, whether it hits or not. On a read miss the cache asks for a line fill. Memory then returns up to four words, one word per beat, through the fill port. A write miss places its word in the cache only when write-allocate is set. Software can enable the cache, clear every entry, or clear one word entry. A hardware disable input and a per-access uncached flag can bypass the cache at any time.

Top module: `wt_data_cache`

## Requirements
- R1: After synchronous reset every word entry is invalid, so the first lookup of any address reports a miss.
- R2: `cpu_hit` is high only when all of these hold: `cpu_req` is high, the cache is active (`ctl_enable` high and `ext_disable` low), `cpu_nocache` is low, the addressed word is valid, and the stored tag equals {`cpu_space`, `cpu_addr[31:8]`}. The line is selected by `cpu_addr[7:4]` and the word by `cpu_addr[3:2]`. On a read hit, `cpu_rdata` is the stored word.
- R3: Valid bits are kept per word. Filling one word of a line does not make the other words of that line hit.
- R4: A fill beat (`fill_valid` while active) writes `fill_data` to the word at `fill_addr`. If {`fill_space`, `fill_addr[31:8]`} differs from the line's tag, the tag is replaced and the line's other valid bits are cleared first. If the tag matches, the other valid bits are kept. The filled word is valid from the next cycle.
- R5: Every CPU write (`cpu_req` and `cpu_we`) appears on the memory write port in the same cycle with the same address, byte enables and data. This holds whether it hits or misses and regardless of enable, disable or uncached.
- R6: A write hit updates only the bytes whose `cpu_be` bit is set. Bit b covers data bits 8b+7 down to 8b.
- R7: On a write miss, the cache changes only when `ctl_walloc` is high. In that case it takes the new tag (clearing the line's other valid bits if the tag differs) and stores the bytes. The word becomes valid only when `cpu_be` is 4'hF.
- R8: `fill_req` is high in the same cycle as a read that misses while the cache is active and the access is cacheable. It is low for hits, writes, uncached accesses and while inactive.
- R9: While `ext_disable` is high or `ctl_enable` is low, nothing hits and no fill or write changes the cache. Contents held from before become visible again when the cache is reactivated.
- R10: `ctl_clear_all` invalidates every word from the next cycle. `ctl_clear_one` invalidates only the word selected by `ctl_clear_addr[7:4]` and `ctl_clear_addr[3:2]`. Both work even while the cache is inactive.
- R11: `cpu_nocache` forces a miss and prevents any cache update by that access, including a write-allocate.
- R12: In one cycle, a clear beats a fill or write to the same word's valid bit. A fill beat beats a CPU write to the same line: that write still goes to memory but does not touch the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Software cache enable |
| ctl_walloc | input | 1 | Write-allocate on write miss |
| ext_disable | input | 1 | Hardware cache disable |
| ctl_clear_all | input | 1 | Invalidate all words |
| ctl_clear_one | input | 1 | Invalidate one word |
| ctl_clear_addr | input | 32 | Address selecting the word to invalidate |
| cpu_req | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 32 | CPU byte address |
| cpu_space | input | 3 | Address-space code of the access |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | CPU write data |
| cpu_nocache | input | 1 | Access is uncachable |
| cpu_hit | output | 1 | Lookup hit |
| cpu_rdata | output | 32 | Read data on hit |
| fill_req | output | 1 | Read miss needs a line fill |
| fill_valid | input | 1 | Fill beat present |
| fill_addr | input | 32 | Address of the fill word |
| fill_space | input | 3 | Address-space code of the fill |
| fill_data | input | 32 | Fill word |
| mem_wr_valid | output | 1 | Write-through strobe |
| mem_wr_addr | output | 32 | Write-through address |
| mem_wr_be | output | 4 | Write-through byte enables |
| mem_wr_data | output | 32 | Write-through data |

## Verification
The collision that matters is a fill beat arriving in the same cycle as a CPU store, or a clear landing on the word a fill is writing. Directed cycles drive a fill and a store to the same line together, and a fill together with a single-word clear of the same word. Later reads then show that the fill data survived and that the cleared word misses. A long random phase uses a narrow address pool, so these overlaps and the clear/allocate overlaps happen often. A behavioural model of tags, valid bits and data judges every cycle.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int SPACE_W = 3;
    localparam int LINES   = 16;
    localparam int WORDS   = 4;
    localparam int BYTES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(BYTES);
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - IDX_W - WSEL_W - OFF_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BYTES-1:0]  be_t;

    typedef struct packed {
        logic [SPACE_W-1:0] space;
        logic [TAG_W-1:0]   atag;
    } tag_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        wsel_t wsel;
        tag_t  tag;
        be_t   be;
        word_t data;
    } wr_op_t;

    function automatic idx_t idx_of(input logic [ADDR_W-1:0] a);
        return a[OFF_W+WSEL_W +: IDX_W];
    endfunction

    function automatic wsel_t wsel_of(input logic [ADDR_W-1:0] a);
        return a[OFF_W +: WSEL_W];
    endfunction

    function automatic tag_t tag_of(input logic [ADDR_W-1:0] a, input logic [SPACE_W-1:0] s);
        return '{space: s, atag: a[ADDR_W-1 -: TAG_W]};
    endfunction

    function automatic word_t merge_bytes(input word_t old_w, input word_t new_w, input be_t be);
        word_t r;
        r = old_w;
        for (int b = 0; b < BYTES; b++)
            if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        return r;
    endfunction

    function automatic logic [WORDS-1:0] word_mask(input wsel_t w, input logic set);
        logic [WORDS-1:0] m;
        m = '0;
        m[w] = set;
        return m;
    endfunction
endpackage

// File: rtl/dc_store.sv
module dc_store
    import dc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  idx_t             rd_idx,
    input  wsel_t            rd_wsel,
    output tag_t             rd_tag,
    output logic [WORDS-1:0] rd_valid,
    output word_t            rd_data,
    input  wr_op_t           fill_op,
    input  wr_op_t           cpu_op,
    input  logic             clr_all,
    input  logic             clr_one,
    input  idx_t             clr_idx,
    input  wsel_t            clr_wsel
);
    tag_t             tag_q   [LINES];
    logic [WORDS-1:0] valid_q [LINES];
    word_t            data_q  [LINES][WORDS];
    logic             any_valid;

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_data  = data_q[rd_idx][rd_wsel];

    always_comb begin
        any_valid = 1'b0;
        for (int i = 0; i < LINES; i++)
            any_valid = any_valid | (|valid_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= '0;
                tag_q[i]   <= '0;
            end
        end else begin
            if (fill_op.en) begin
                if (tag_q[fill_op.idx] != fill_op.tag) begin
                    tag_q[fill_op.idx]   <= fill_op.tag;
                    valid_q[fill_op.idx] <= word_mask(fill_op.wsel, 1'b1);
                end else begin
                    valid_q[fill_op.idx] <= valid_q[fill_op.idx] | word_mask(fill_op.wsel, 1'b1);
                end
                data_q[fill_op.idx][fill_op.wsel] <= fill_op.data;
            end
            if (cpu_op.en) begin
                if (tag_q[cpu_op.idx] != cpu_op.tag) begin
                    tag_q[cpu_op.idx]   <= cpu_op.tag;
                    valid_q[cpu_op.idx] <= word_mask(cpu_op.wsel, &cpu_op.be);
                end else begin
                    valid_q[cpu_op.idx] <= valid_q[cpu_op.idx] | word_mask(cpu_op.wsel, &cpu_op.be);
                end
                data_q[cpu_op.idx][cpu_op.wsel] <=
                    merge_bytes(data_q[cpu_op.idx][cpu_op.wsel], cpu_op.data, cpu_op.be);
            end
            if (clr_one)
                valid_q[clr_idx][clr_wsel] <= 1'b0;
            if (clr_all)
                for (int i = 0; i < LINES; i++)
                    valid_q[i] <= '0;
        end
    end

    AST_CLEAR_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> !any_valid);  // R10

    AST_FILL_MARKS_WORD: assert property (@(posedge clk) disable iff (rst)
        (fill_op.en && !clr_all && !(clr_one && clr_idx == fill_op.idx && clr_wsel == fill_op.wsel))
        |=> valid_q[$past(fill_op.idx)][$past(fill_op.wsel)]);  // R4

    AST_NEWTAG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (fill_op.en && tag_q[fill_op.idx] != fill_op.tag)
        |=> ($countones(valid_q[$past(fill_op.idx)]) <= 1));  // R4
endmodule

// File: rtl/dc_lookup.sv
module dc_lookup
    import dc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_enable,
    input  logic               ctl_walloc,
    input  logic               ext_disable,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [SPACE_W-1:0] cpu_space,
    input  be_t                cpu_be,
    input  word_t              cpu_wdata,
    input  logic               cpu_nocache,
    input  logic               fill_valid,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic [SPACE_W-1:0] fill_space,
    input  word_t              fill_data,
    input  tag_t               rd_tag,
    input  logic [WORDS-1:0]   rd_valid,
    input  word_t              rd_data,
    output idx_t               rd_idx,
    output wsel_t              rd_wsel,
    output logic               cpu_hit,
    output word_t              cpu_rdata,
    output logic               fill_req,
    output wr_op_t             fill_op,
    output wr_op_t             cpu_op
);
    logic active;
    logic cacheable;
    tag_t cpu_tag;

    assign active    = ctl_enable && !ext_disable;
    assign cacheable = active && cpu_req && !cpu_nocache;
    assign cpu_tag   = tag_of(cpu_addr, cpu_space);
    assign rd_idx    = idx_of(cpu_addr);
    assign rd_wsel   = wsel_of(cpu_addr);

    assign cpu_hit   = cacheable && rd_valid[rd_wsel] && (rd_tag == cpu_tag);
    assign cpu_rdata = rd_data;
    assign fill_req  = cacheable && !cpu_we && !cpu_hit;

    always_comb begin
        fill_op      = '0;
        fill_op.en   = fill_valid && active;
        fill_op.idx  = idx_of(fill_addr);
        fill_op.wsel = wsel_of(fill_addr);
        fill_op.tag  = tag_of(fill_addr, fill_space);
        fill_op.be   = '1;
        fill_op.data = fill_data;

        cpu_op       = '0;
        cpu_op.en    = cacheable && cpu_we && (cpu_hit || ctl_walloc)
                       && !(fill_op.en && fill_op.idx == rd_idx);
        cpu_op.idx   = rd_idx;
        cpu_op.wsel  = rd_wsel;
        cpu_op.tag   = cpu_tag;
        cpu_op.be    = cpu_be;
        cpu_op.data  = cpu_wdata;
    end

    AST_HIT_GATED: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> (ctl_enable && !ext_disable && !cpu_nocache));  // R9

    AST_NOCACHE_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        cpu_nocache |-> !cpu_op.en);  // R11

    AST_MISS_REQ: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> (!cpu_hit && !cpu_we));  // R8

    AST_FILL_WINS: assert property (@(posedge clk) disable iff (rst)
        (fill_op.en && cpu_op.en) |-> (fill_op.idx != cpu_op.idx));  // R12
endmodule

// File: rtl/wt_data_cache.sv
module wt_data_cache
    import dc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_enable,
    input  logic               ctl_walloc,
    input  logic               ext_disable,
    input  logic               ctl_clear_all,
    input  logic               ctl_clear_one,
    input  logic [ADDR_W-1:0]  ctl_clear_addr,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [SPACE_W-1:0] cpu_space,
    input  logic [BYTES-1:0]   cpu_be,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_nocache,
    output logic               cpu_hit,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               fill_req,
    input  logic               fill_valid,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic [SPACE_W-1:0] fill_space,
    input  logic [DATA_W-1:0]  fill_data,
    output logic               mem_wr_valid,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [BYTES-1:0]   mem_wr_be,
    output logic [DATA_W-1:0]  mem_wr_data
);
    idx_t             rd_idx;
    wsel_t            rd_wsel;
    tag_t             rd_tag;
    logic [WORDS-1:0] rd_valid;
    word_t            rd_data;
    wr_op_t           fill_op;
    wr_op_t           cpu_op;

    dc_lookup u_lookup (
        .clk         (clk),
        .rst         (rst),
        .ctl_enable  (ctl_enable),
        .ctl_walloc  (ctl_walloc),
        .ext_disable (ext_disable),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_space   (cpu_space),
        .cpu_be      (cpu_be),
        .cpu_wdata   (cpu_wdata),
        .cpu_nocache (cpu_nocache),
        .fill_valid  (fill_valid),
        .fill_addr   (fill_addr),
        .fill_space  (fill_space),
        .fill_data   (fill_data),
        .rd_tag      (rd_tag),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rd_idx      (rd_idx),
        .rd_wsel     (rd_wsel),
        .cpu_hit     (cpu_hit),
        .cpu_rdata   (cpu_rdata),
        .fill_req    (fill_req),
        .fill_op     (fill_op),
        .cpu_op      (cpu_op)
    );

    dc_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_wsel  (rd_wsel),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .fill_op  (fill_op),
        .cpu_op   (cpu_op),
        .clr_all  (ctl_clear_all),
        .clr_one  (ctl_clear_one),
        .clr_idx  (idx_of(ctl_clear_addr)),
        .clr_wsel (wsel_of(ctl_clear_addr))
    );

    assign mem_wr_valid = cpu_req && cpu_we;
    assign mem_wr_addr  = cpu_addr;
    assign mem_wr_be    = cpu_be;
    assign mem_wr_data  = cpu_wdata;
endmodule

// File: tb/sim_wt_data_cache.sv
module sim_wt_data_cache;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_enable, ctl_walloc, ext_disable, ctl_clear_all, ctl_clear_one;
    logic [31:0] ctl_clear_addr;
    logic        cpu_req, cpu_we, cpu_nocache;
    logic [31:0] cpu_addr, cpu_wdata;
    logic [2:0]  cpu_space;
    logic [3:0]  cpu_be;
    logic        cpu_hit, fill_req, fill_valid, mem_wr_valid;
    logic [31:0] cpu_rdata, fill_addr, fill_data, mem_wr_addr, mem_wr_data;
    logic [2:0]  fill_space;
    logic [3:0]  mem_wr_be;

    int n_chk = 0;
    int n_fail = 0;

    logic [26:0] m_tag [16];
    logic [3:0]  m_val [16];
    logic [31:0] m_dat [16][4];

    always #(PER/2) clk = ~clk;

    wt_data_cache u0 (.*);

    function automatic logic [26:0] mtag(input logic [31:0] a, input logic [2:0] s);
        return {s, a[31:8]};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cpu_req = 0; cpu_we = 0; cpu_nocache = 0; cpu_addr = 0; cpu_space = 0;
        cpu_be = 0; cpu_wdata = 0; fill_valid = 0; fill_addr = 0; fill_space = 0;
        fill_data = 0; ctl_clear_all = 0; ctl_clear_one = 0; ctl_clear_addr = 0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [2:0] s);
        cpu_req = 1; cpu_we = 0; cpu_addr = a; cpu_space = s;
    endtask

    task automatic wr(input logic [31:0] a, input logic [2:0] s, input logic [3:0] be, input logic [31:0] d);
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_space = s; cpu_be = be; cpu_wdata = d;
    endtask

    task automatic fl(input logic [31:0] a, input logic [2:0] s, input logic [31:0] d);
        fill_valid = 1; fill_addr = a; fill_space = s; fill_data = d;
    endtask

    // One clock: compare outputs mid-cycle against the model, then advance the model.
    task automatic step(input string req);
        logic act_on, eh, fon;
        int i, w, fi, fw;
        #(PER/4);
        act_on = ctl_enable && !ext_disable;
        i = int'(cpu_addr[7:4]);
        w = int'(cpu_addr[3:2]);
        eh = act_on && cpu_req && !cpu_nocache && m_val[i][w] && (m_tag[i] == mtag(cpu_addr, cpu_space));
        chk(req, "hit", {31'd0, cpu_hit}, {31'd0, eh});
        chk("R8", "fill_req", {31'd0, fill_req}, {31'd0, act_on && cpu_req && !cpu_we && !cpu_nocache && !eh});
        chk("R5", "mem_wr_valid", {31'd0, mem_wr_valid}, {31'd0, cpu_req && cpu_we});
        if (cpu_req && cpu_we) begin
            chk("R5", "mem_wr_addr", mem_wr_addr, cpu_addr);
            chk("R5", "mem_wr_data", mem_wr_data, cpu_wdata);
            chk("R5", "mem_wr_be", {28'd0, mem_wr_be}, {28'd0, cpu_be});
        end
        if (eh && !cpu_we) chk(req, "rdata", cpu_rdata, m_dat[i][w]);
        @(posedge clk);
        fi  = int'(fill_addr[7:4]);
        fw  = int'(fill_addr[3:2]);
        fon = fill_valid && act_on;
        if (fon) begin
            if (m_tag[fi] != mtag(fill_addr, fill_space)) begin
                m_tag[fi] = mtag(fill_addr, fill_space);
                m_val[fi] = 4'b0;
            end
            m_val[fi][fw] = 1'b1;
            m_dat[fi][fw] = fill_data;
        end
        if (act_on && cpu_req && cpu_we && !cpu_nocache && (eh || ctl_walloc) && !(fon && fi == i)) begin
            if (m_tag[i] != mtag(cpu_addr, cpu_space)) begin
                m_tag[i] = mtag(cpu_addr, cpu_space);
                m_val[i] = 4'b0;
            end
            for (int b = 0; b < 4; b++)
                if (cpu_be[b]) m_dat[i][w][8*b +: 8] = cpu_wdata[8*b +: 8];
            if (cpu_be == 4'hF) m_val[i][w] = 1'b1;
        end
        if (ctl_clear_one) m_val[ctl_clear_addr[7:4]][ctl_clear_addr[3:2]] = 1'b0;
        if (ctl_clear_all) for (int k = 0; k < 16; k++) m_val[k] = 4'b0;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(PER*200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            m_tag[k] = '0;
            m_val[k] = '0;
            for (int j = 0; j < 4; j++) m_dat[k][j] = '0;
        end
        idle();
        ctl_enable = 1; ctl_walloc = 0; ext_disable = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: nothing hits after reset
        rd(32'h1234_5610, 3'd1); step("R1");
        rd(32'h0000_0000, 3'd0); step("R1");

        // R4 / R2 / R3: one word filled
        fl(32'h1234_5610, 3'd1, 32'h1111_1111); step("R4");
        rd(32'h1234_5610, 3'd1); step("R2");
        rd(32'h1234_5614, 3'd1); step("R3");
        rd(32'h1234_5610, 3'd5); step("R2");
        rd(32'h00AB_CD10, 3'd1); step("R2");

        // R4: new tag on same line drops old words
        fl(32'h00AB_CD14, 3'd1, 32'h2222_2222); step("R4");
        rd(32'h1234_5610, 3'd1); step("R4");
        rd(32'h00AB_CD14, 3'd1); step("R4");

        // R6: partial write hit
        wr(32'h00AB_CD14, 3'd1, 4'b0011, 32'hAAAA_5555); step("R6");
        rd(32'h00AB_CD14, 3'd1); step("R6");

        // R7: write-allocate control
        wr(32'h00AB_CD28, 3'd1, 4'hF, 32'h3333_3333); step("R7");
        rd(32'h00AB_CD28, 3'd1); step("R7");
        ctl_walloc = 1;
        wr(32'h00AB_CD28, 3'd1, 4'hF, 32'h4444_4444); step("R7");
        rd(32'h00AB_CD28, 3'd1); step("R7");
        wr(32'h00AB_CD2C, 3'd1, 4'h1, 32'h0000_0099); step("R7");
        rd(32'h00AB_CD2C, 3'd1); step("R7");

        // R8: read vs write miss
        wr(32'h0000_0F00, 3'd2, 4'hF, 32'h5); step("R8");

        // R9: disable paths
        ext_disable = 1;
        rd(32'h00AB_CD28, 3'd1); step("R9");
        fl(32'h00AB_CD30, 3'd1, 32'h6666_6666); step("R9");
        ext_disable = 0;
        rd(32'h00AB_CD30, 3'd1); step("R9");
        ctl_enable = 0;
        rd(32'h00AB_CD28, 3'd1); step("R9");
        ctl_enable = 1;
        rd(32'h00AB_CD28, 3'd1); step("R9");

        // R11: uncached access
        cpu_nocache = 1; rd(32'h00AB_CD28, 3'd1); step("R11");
        cpu_nocache = 1; wr(32'h00AB_CD30, 3'd1, 4'hF, 32'h7777_7777); step("R11");
        rd(32'h00AB_CD30, 3'd1); step("R11");

        // R10: clears
        ctl_clear_one = 1; ctl_clear_addr = 32'h00AB_CD28; step("R10");
        rd(32'h00AB_CD28, 3'd1); step("R10");
        fl(32'h00AB_CD50, 3'd1, 32'h8888_8888); step("R10");
        ctl_clear_all = 1; step("R10");
        rd(32'h00AB_CD50, 3'd1); step("R10");
        rd(32'h00AB_CD14, 3'd1); step("R10");

        // R12: same-cycle collisions
        fl(32'h00AB_CD50, 3'd1, 32'h9999_9999);
        ctl_clear_one = 1; ctl_clear_addr = 32'h00AB_CD50; step("R12");
        rd(32'h00AB_CD50, 3'd1); step("R12");
        fl(32'h00AB_CD54, 3'd1, 32'hABCD_0001);
        wr(32'h00AB_CD58, 3'd1, 4'hF, 32'hDEAD_BEEF); step("R12");
        rd(32'h00AB_CD54, 3'd1); step("R12");
        rd(32'h00AB_CD58, 3'd1); step("R12");

        // Random mix over a narrow address pool (R2 R4 R6 R7 R10 R12)
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, fa;
            a  = {(($urandom % 2) != 0) ? 24'h123456 : 24'h00ABCD, 3'b000, 1'($urandom), 2'($urandom), 2'b00};
            fa = {(($urandom % 2) != 0) ? 24'h123456 : 24'h00ABCD, 3'b000, 1'($urandom), 2'($urandom), 2'b00};
            ctl_enable  = ($urandom % 16) != 0;
            ext_disable = ($urandom % 20) == 0;
            ctl_walloc  = ($urandom % 2) != 0;
            if (($urandom % 4) != 0) begin
                if (($urandom % 2) != 0)
                    wr(a, (($urandom % 4) != 0) ? 3'd1 : 3'd5,
                       (($urandom % 2) != 0) ? 4'hF : 4'($urandom), $urandom);
                else
                    rd(a, (($urandom % 4) != 0) ? 3'd1 : 3'd5);
                cpu_nocache = ($urandom % 12) == 0;
            end
            if (($urandom % 3) == 0) fl(fa, (($urandom % 4) != 0) ? 3'd1 : 3'd5, $urandom);
            ctl_clear_one  = ($urandom % 16) == 0;
            ctl_clear_addr = ($urandom % 2) != 0 ? a : fa;
            ctl_clear_all  = ($urandom % 64) == 0;
            step("R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule